// File: doc/BRIEF.md
# Display-Clock PLL Divider Reprogramming Sequencer

This block changes the divider settings of a display-clock PLL in a safe, fixed order. A client presents one request with four encoded divider codes: input divider, feedback count, odd/even select and post divider. The block packs them into a 32-bit clock-control word and writes that word through a single-cycle write strobe and data port. It writes the new dividers first. A second write puts the PLL into feedback reset and bypass. The block then waits a settling time given in system clock cycles, clears feedback reset in one write, and clears bypass in a later, separate write.

The settle time is derived from two parameters, the system clock frequency and the settling time in microseconds (default 500). The cycle count is rounded up, so the wait is never shorter than asked. The block accepts a request only while idle. A request that arrives while a sequence runs is discarded and flagged. A one-cycle done pulse closes each sequence.

Top module: `dclk_reprog_seq`

## Requirements
- R1: While reset is held and on its release, regWrEn, busy, done and reqDropped are all 0.
- R2: Every written word carries the post-divider code in bits [28:24], the odd/even select in bit 23, the feedback count in bits [22:12] and the input-divider code in bits [2:0]. Feedback reset is bit 31 and bypass is bit 8. All other bits (30:29, 11:9, 7:3) are 0.
- R3: An accepted request produces exactly four writes. The first comes in the cycle after the request is sampled and carries the new fields with bits 31 and 8 both 0.
- R4: The second write follows the first in the next cycle and carries the same fields with bits 31 and 8 both 1.
- R5: The third write follows the second by exactly SETTLE_CYCLES+1 cycles, where SETTLE_CYCLES = ceil(SYS_CLK_HZ*SETTLE_US/1e6). It is therefore never sooner than the settle time.
- R6: The third write carries the same fields with bit 31 = 0 and bit 8 = 1.
- R7: The fourth write follows the third in the next cycle and carries the same fields with bits 31 and 8 both 0.
- R8: done is high for exactly one cycle, the cycle after the fourth write, and busy is 0 in that cycle.
- R9: busy is 1 from the cycle after a request is accepted until done rises. A request sampled with busy at 0 is accepted, including one in the cycle done is high.
- R10: A request sampled while busy is 1 has no effect on the writes or their values. It raises reqDropped for one cycle, the cycle after it was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request to reprogram the dividers |
| reqIdiv | input | 3 | Input-divider code |
| reqFbN | input | 11 | Feedback count code |
| reqOdd | input | 1 | Odd feedback select (adds one to 2*N) |
| reqPdiv | input | 5 | Post-divider code |
| regWrEn | output | 1 | One-cycle write strobe to the clock-control register |
| regWrData | output | 32 | Full word written with the strobe |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse after the final write |
| reqDropped | output | 1 | One-cycle pulse for a request ignored while busy |

## Verification
A wrong sequencer state shows up at the ports within a cycle. It appears as a missing, extra or misordered write, or as a word whose bits 31 and 8 do not match their step. A settle counter that is loaded or ended wrongly moves the third write away from its exact spacing after the second. That error is visible at the third strobe, about SETTLE_CYCLES cycles after entry. A corrupt latched divider field or a request accepted while busy changes the data of the very next write. A bad idle decision shows as a missing reqDropped pulse, or as a missing start one cycle after a request.

// File: rtl/dclk_reprog_pkg.sv
package dclk_reprog_pkg;

  localparam int IDIV_W  = 3;
  localparam int FBN_W   = 11;
  localparam int PDIV_W  = 5;

  localparam int IDIV_LSB = 0;
  localparam int BYP_BIT  = 8;
  localparam int FBN_LSB  = 12;
  localparam int ODD_BIT  = 23;
  localparam int PDIV_LSB = 24;
  localparam int RST_BIT  = 31;

  typedef struct packed {
    logic [PDIV_W-1:0] pdiv;
    logic              odd;
    logic [FBN_W-1:0]  fbN;
    logic [IDIV_W-1:0] idiv;
  } divCfg_t;

  typedef struct packed {
    logic load;
    logic write;
    logic setRst;
    logic setByp;
    logic done;
    logic drop;
  } seqStrb_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIELDS,
    ST_HOLD,
    ST_SETTLE,
    ST_RELRST,
    ST_RELBYP,
    ST_FINISH
  } seqState_t;

  function automatic logic [31:0] packFields(divCfg_t c);
    logic [31:0] w;
    w = '0;
    w[PDIV_LSB +: PDIV_W] = c.pdiv;
    w[ODD_BIT]            = c.odd;
    w[FBN_LSB  +: FBN_W]  = c.fbN;
    w[IDIV_LSB +: IDIV_W] = c.idiv;
    return w;
  endfunction

endpackage

// File: rtl/dclk_reprog_ctrl.sv
module dclk_reprog_ctrl
  import dclk_reprog_pkg::*;
#(
  parameter longint unsigned SETTLE_CYCLES = 1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     reqValid,
  output seqStrb_t strb,
  output logic     busy
);

  localparam int CNT_W = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES - 1);

  seqState_t      state;
  logic [CNT_W-1:0] settleCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      settleCnt <= '0;
    end else begin
      case (state)
        ST_IDLE:   if (reqValid) state <= ST_FIELDS;
        ST_FIELDS: state <= ST_HOLD;
        ST_HOLD: begin
          state     <= ST_SETTLE;
          settleCnt <= CNT_LOAD;
        end
        ST_SETTLE: begin
          if (settleCnt == '0) state <= ST_RELRST;
          else                 settleCnt <= settleCnt - 1'b1;
        end
        ST_RELRST: state <= ST_RELBYP;
        ST_RELBYP: state <= ST_FINISH;
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb      = '0;
    busy      = (state != ST_IDLE);
    strb.load = (state == ST_IDLE) && reqValid;
    strb.drop = busy && reqValid;
    case (state)
      ST_FIELDS: strb.write = 1'b1;
      ST_HOLD: begin
        strb.write  = 1'b1;
        strb.setRst = 1'b1;
        strb.setByp = 1'b1;
      end
      ST_RELRST: begin
        strb.write  = 1'b1;
        strb.setByp = 1'b1;
      end
      ST_RELBYP: strb.write = 1'b1;
      ST_FINISH: strb.done  = 1'b1;
      default: ;
    endcase
  end

  // R9: once the final write is issued, the next cycle is the done cycle
  a_r9_relbyp_then_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RELBYP) |=> (state == ST_FINISH && busy));

  // R10: a sampled request while busy never reloads the sequence
  a_r10_busy_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state != ST_FINISH) |=> busy);

endmodule

// File: rtl/dclk_reprog_dpath.sv
module dclk_reprog_dpath
  import dclk_reprog_pkg::*;
#(
  parameter longint unsigned SETTLE_CYCLES = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  divCfg_t     reqCfg,
  input  seqStrb_t    strb,
  output logic        regWrEn,
  output logic [31:0] regWrData,
  output logic        done,
  output logic        reqDropped
);

  localparam logic [31:0] DEFINED_MASK =
      (32'((1 << PDIV_W) - 1) << PDIV_LSB) | (32'h1 << ODD_BIT) |
      (32'((1 << FBN_W) - 1) << FBN_LSB)  | (32'((1 << IDIV_W) - 1) << IDIV_LSB) |
      (32'h1 << RST_BIT) | (32'h1 << BYP_BIT);
  localparam int GAP_W = $clog2(SETTLE_CYCLES + 4);

  divCfg_t cfgQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfgQ       <= '0;
      regWrEn    <= 1'b0;
      regWrData  <= '0;
      done       <= 1'b0;
      reqDropped <= 1'b0;
    end else begin
      if (strb.load) cfgQ <= reqCfg;
      regWrEn    <= strb.write;
      done       <= strb.done;
      reqDropped <= strb.drop;
      if (strb.write) begin
        regWrData          <= packFields(cfgQ);
        regWrData[RST_BIT] <= strb.setRst;
        regWrData[BYP_BIT] <= strb.setByp;
      end else begin
        regWrData <= '0;
      end
    end
  end

  // Checker state: cycles elapsed since a write with feedback reset set
  logic             holdArmed;
  logic [GAP_W-1:0] sinceHold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      holdArmed <= 1'b0;
      sinceHold <= '0;
    end else if (regWrEn) begin
      holdArmed <= regWrData[RST_BIT];
      sinceHold <= GAP_W'(1);
    end else if (holdArmed && sinceHold != '1) begin
      sinceHold <= sinceHold + 1'b1;
    end
  end

  // R2: reserved bits are zero in every written word
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    regWrEn |-> ((regWrData & ~DEFINED_MASK) == 32'h0));

  // R5: reset is released no sooner than the settle time after it was set
  a_r5_settle_respected: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && holdArmed && !regWrData[RST_BIT]) |-> (longint'(sinceHold) >= SETTLE_CYCLES));

  // R6: reset release keeps bypass on
  a_r6_release_keeps_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && holdArmed) |-> (regWrData[BYP_BIT] && !regWrData[RST_BIT]));

  // R8: done is a single-cycle pulse right after a write with both controls clear
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_after_final: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(regWrEn) && !$past(regWrData[BYP_BIT]) && !$past(regWrData[RST_BIT])));

endmodule

// File: rtl/dclk_reprog_seq.sv
module dclk_reprog_seq
  import dclk_reprog_pkg::*;
#(
  parameter longint unsigned SYS_CLK_HZ = 100_000_000,
  parameter longint unsigned SETTLE_US  = 500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic [2:0]  reqIdiv,
  input  logic [10:0] reqFbN,
  input  logic        reqOdd,
  input  logic [4:0]  reqPdiv,
  output logic        regWrEn,
  output logic [31:0] regWrData,
  output logic        busy,
  output logic        done,
  output logic        reqDropped
);

  localparam longint unsigned RAW_CYCLES =
      (SYS_CLK_HZ * SETTLE_US + 64'd999_999) / 64'd1_000_000;
  localparam longint unsigned SETTLE_CYCLES = (RAW_CYCLES < 1) ? 1 : RAW_CYCLES;

  divCfg_t  reqCfg;
  seqStrb_t strb;

  assign reqCfg = '{pdiv: reqPdiv, odd: reqOdd, fbN: reqFbN, idiv: reqIdiv};

  dclk_reprog_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .strb     (strb),
    .busy     (busy)
  );

  dclk_reprog_dpath #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqCfg     (reqCfg),
    .strb       (strb),
    .regWrEn    (regWrEn),
    .regWrData  (regWrData),
    .done       (done),
    .reqDropped (reqDropped)
  );

endmodule

// File: tb/dclk_reprog_seq_bench.sv
module dclk_reprog_seq_bench;

  localparam int S = 100;   // ceil(199_999 * 500 / 1e6)

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqIdiv = '0;
  logic [10:0] reqFbN = '0;
  logic        reqOdd = 1'b0;
  logic [4:0]  reqPdiv = '0;
  logic        regWrEn;
  logic [31:0] regWrData;
  logic        busy, done, reqDropped;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  dclk_reprog_seq #(.SYS_CLK_HZ(199_999), .SETTLE_US(500)) u_dclk_reprog_seq (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqIdiv(reqIdiv),
    .reqFbN(reqFbN), .reqOdd(reqOdd), .reqPdiv(reqPdiv), .regWrEn(regWrEn),
    .regWrData(regWrData), .busy(busy), .done(done), .reqDropped(reqDropped)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] wrData [8];
  int          wrCyc  [8];
  int          wrCount = 0;
  int          doneCyc = -1;
  int          doneCnt = 0;
  int          dropCnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (regWrEn) begin
        if (wrCount < 8) begin
          wrData[wrCount] = regWrData;
          wrCyc[wrCount]  = cyc;
        end
        wrCount++;
      end
      if (done) begin
        doneCyc = cyc;
        doneCnt++;
      end
      if (reqDropped) dropCnt++;
    end
  end

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expWord(logic [2:0] id, logic [10:0] n, logic od,
                                          logic [4:0] pd, logic r, logic b);
    return (32'(pd) << 24) | (32'(od) << 23) | (32'(n) << 12) | 32'(id) |
           (32'(r) << 31) | (32'(b) << 8);
  endfunction

  task automatic clearLog();
    wrCount = 0; doneCyc = -1; doneCnt = 0; dropCnt = 0;
  endtask

  // inject: 0 none, 1 request mid-settle, 2 request held two cycles
  task automatic runSeq(string name, logic [2:0] id, logic [10:0] n, logic od,
                        logic [4:0] pd, int inject);
    int reqCyc;
    int t;
    clearLog();
    @(negedge clk);
    reqIdiv = id; reqFbN = n; reqOdd = od; reqPdiv = pd; reqValid = 1'b1;
    reqCyc = cyc + 1;
    @(negedge clk);
    check({"R9 busy after accept ", name}, busy, 1);
    if (inject == 2) begin
      @(negedge clk);
      check({"R10 drop held request ", name}, reqDropped, 1);
    end
    reqValid = 1'b0;
    if (inject == 1) begin
      repeat (20) @(negedge clk);
      reqIdiv = ~id; reqFbN = ~n; reqOdd = ~od; reqPdiv = ~pd; reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
      check({"R10 drop mid-settle ", name}, reqDropped, 1);
      check({"R10 still busy ", name}, busy, 1);
    end
    t = 0;
    while (doneCnt == 0 && t < 2000) begin
      @(negedge clk);
      t++;
    end
    check({"R8 done seen ", name}, doneCnt, 1);
    check({"R8 busy low at done ", name}, busy, 0);
    @(negedge clk);
    check({"R8 done single ", name}, done, 0);
    check({"R3 four writes ", name}, wrCount, 4);
    if (wrCount >= 4) begin
      check({"R3 first write cycle ", name}, wrCyc[0], reqCyc + 1);
      check({"R3 R2 fields word ", name}, wrData[0], expWord(id, n, od, pd, 0, 0));
      check({"R4 hold word ", name}, wrData[1], expWord(id, n, od, pd, 1, 1));
      check({"R4 hold cycle ", name}, wrCyc[1] - wrCyc[0], 1);
      check({"R5 settle gap ", name}, wrCyc[2] - wrCyc[1], S + 1);
      check({"R6 release reset word ", name}, wrData[2], expWord(id, n, od, pd, 0, 1));
      check({"R7 release bypass word ", name}, wrData[3], expWord(id, n, od, pd, 0, 0));
      check({"R7 release bypass cycle ", name}, wrCyc[3] - wrCyc[2], 1);
      check({"R8 done cycle ", name}, doneCyc, wrCyc[3] + 1);
    end
    check({"R10 drop count ", name}, dropCnt, (inject != 0) ? 1 : 0);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R1 regWrEn in reset", regWrEn, 0);
    check("R1 busy in reset", busy, 0);
    check("R1 done in reset", done, 0);
    check("R1 reqDropped in reset", reqDropped, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {regWrEn, busy, done, reqDropped}, 0);
  endtask

  task automatic testRestartAtDone();
    // a request presented in the done cycle is accepted (R9)
    int t;
    clearLog();
    @(negedge clk);
    reqIdiv = 3'd2; reqFbN = 11'h155; reqOdd = 1'b0; reqPdiv = 5'h0A; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    t = 0;
    while (!done && t < 2000) begin
      @(negedge clk);
      t++;
    end
    reqIdiv = 3'd6; reqFbN = 11'h0AA; reqOdd = 1'b1; reqPdiv = 5'h15; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check("R9 accept in done cycle busy", busy, 1);
    check("R10 no drop when idle", reqDropped, 0);
    @(negedge clk);
    check("R9 restart first write", regWrEn, 1);
    check("R9 restart word", regWrData, expWord(3'd6, 11'h0AA, 1'b1, 5'h15, 0, 0));
    t = 0;
    while (busy && t < 2000) begin
      @(negedge clk);
      t++;
    end
    check("R9 restart finishes", busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    testReset();
    runSeq("example", 3'b101, 11'h073, 1'b0, 5'b00111, 0);
    runSeq("all ones", 3'h7, 11'h7FF, 1'b1, 5'h1F, 0);
    runSeq("sparse", 3'h1, 11'h401, 1'b1, 5'h10, 1);
    runSeq("held", 3'h4, 11'h2AA, 1'b0, 5'h01, 2);
    testRestartAtDone();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule